// File: doc/BRIEF.md
# LCD Controller Configuration Register File

This block holds the configuration of an LCD display controller and gives a microcontroller access to it. The microcontroller uses a small bus with a 5-bit address, a bidirectional 8-bit data bus and three active-low strobes: chip select, write and read. Every stored value is also exported as a parallel output, so the timing generator, the pixel path and the pulse generator read their settings directly.

The array has thirty 8-bit registers. Address 0 is the mode register. Addresses 1 to 12 hold six 16-bit geometry values, each split into a low byte and a high byte. Address 13 holds the colour order for odd and even lines. Addresses 14 to 29 hold the pulse-waveform parameters. Bit 0 of the mode register has two roles. It is the idle flag that the microcontroller reads, and it is also the reset line for the rest of the controller. Hardware sets this bit back to 1 when the timing block reports that a display has ended.

The bus strobes are asynchronous to the block clock. A write takes effect on the rising edge of the write strobe. The strobe passes through a three-flop synchronizer, and the register commits on the third clock edge after the strobe rises. Reads are combinational: the data bus is driven only while chip select and read strobe are both low.

Top module: `lcd_cfg_regs`

## Requirements
- R1: After reset, the mode register reads 0x01, so the controller is idle and held in reset. Every other register reads 0x00.
- R2: With chip select low, a rising edge of the write strobe stores the data bus into the addressed register. The stored value appears on the exported outputs and in read-back from the third clock edge after the strobe rises.
- R3: A write strobe edge while chip select is high changes no register.
- R4: While chip select and read strobe are both low, the data bus carries the addressed register. Otherwise the block leaves the data bus undriven.
- R5: Addresses 30 and 31 read as 0x00. A write to either address changes no register.
- R6: The mode register is laid out as follows. Bit 0 is idle/reset, exported on `ctl_idle_rst`. Bit 1 is the vertical direction: 1 means top to bottom. Bit 2 is the horizontal direction: 1 means left to right. Bits 5:3 are the panel select. Bit 6 selects live framing (1) or still playback (0). Bit 7 always reads 0, whatever value is written to it.
- R7: The geometry values each take two consecutive addresses, with the low byte at the lower address. Total rows uses addresses 1 and 2, total columns 3 and 4, first row 5 and 6, last row 7 and 8, first column 9 and 10, and last column 11 and 12. Each value is exported as 16 bits.
- R8: Register 13 is exported as `color_order`. Registers 14 to 29 are exported on `pulse_cfg`, with register 14+k in bits [8k+7:8k].
- R9: A one-cycle `disp_end` pulse sets mode bit 0 to 1 on the following clock edge and leaves the other mode bits unchanged. If a write to the mode register commits on the same edge, the written value is kept except that bit 0 is 1.
- R10: Writing 0 to mode bit 0 clears `ctl_idle_rst`, which releases the rest of the controller.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bus_addr | input | 5 | Register address from the microcontroller |
| bus_data | inout | 8 | Bidirectional data bus |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_wr_n | input | 1 | Write strobe, active low; the write commits on its rising edge |
| bus_rd_n | input | 1 | Read strobe, active low |
| disp_end | input | 1 | One-cycle display-finished pulse from the timing block |
| ctl_idle_rst | output | 1 | Idle flag and reset for the rest of the controller (mode bit 0) |
| scan_top_down | output | 1 | Vertical scan direction (mode bit 1) |
| scan_left_right | output | 1 | Horizontal scan direction (mode bit 2) |
| panel_sel | output | 3 | Panel type select (mode bits 5:3) |
| live_view | output | 1 | Live framing (1) or playback (0) (mode bit 6) |
| rows_total | output | 16 | Total rows per frame |
| cols_total | output | 16 | Total columns per line |
| row_first | output | 16 | First displayed row |
| row_last | output | 16 | Last displayed row |
| col_first | output | 16 | First displayed column |
| col_last | output | 16 | Last displayed column |
| color_order | output | 8 | Odd/even line colour order code |
| pulse_cfg | output | 128 | Pulse-waveform parameters, one byte per register |

## Verification
The assertions assume several things about the bus inputs:
- Address, data and chip select stay stable while the write strobe is low and for a few clock cycles after it rises, so the synchronized copies match when the write commits.
- `disp_end` is a single-cycle pulse.
- The write strobe stays in each state for at least three clock cycles.

The stimulus changes bus inputs only on falling clock edges. It holds every field for at least four cycles on each side of the strobe edge, and it times `disp_end` against the known three-edge commit latency.

// File: rtl/lcd_cfg_pkg.sv
package lcd_cfg_pkg;
    // register map offsets
    localparam int MODE_ADDR   = 0;
    localparam int GEO_BASE    = 1;
    localparam int N_GEO       = 6;
    localparam int COLOR_ADDR  = GEO_BASE + 2 * N_GEO;
    localparam int PULSE_BASE  = COLOR_ADDR + 1;

    // mode register bit positions
    localparam int MB_IDLE     = 0;
    localparam int MB_VDIR     = 1;
    localparam int MB_HDIR     = 2;
    localparam int MB_PANEL    = 3;
    localparam int MB_LIVE     = 6;
    localparam logic [7:0] MODE_MASK  = 8'h7F;
    localparam logic [7:0] MODE_RESET = 8'h01;

    // one synchronizer stage of the bus
    typedef struct packed {
        logic       cs_n;
        logic       wr_n;
        logic [4:0] addr;
        logic [7:0] data;
    } bus_stage_t;
endpackage

// File: rtl/lcd_bus_sync.sv
module lcd_bus_sync
    import lcd_cfg_pkg::*;
#(
    parameter int STAGES = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] bus_addr,
    input  logic [7:0] bus_din,
    input  logic       bus_cs_n,
    input  logic       bus_wr_n,
    output logic       wr_en,
    output logic [4:0] wr_addr,
    output logic [7:0] wr_data
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        bus_stage_t [STAGES-1:0] st;
    } sync_t;

    sync_t sync_d, sync_q;
    localparam bus_stage_t IDLE_STAGE = '{cs_n: 1'b1, wr_n: 1'b1, addr: '0, data: '0};

    always_comb begin
        sync_d = sync_q;
        sync_d.st[0] = '{cs_n: bus_cs_n, wr_n: bus_wr_n, addr: bus_addr, data: bus_din};
        for (int i = 1; i < STAGES; i++) begin
            sync_d.st[i] = sync_q.st[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) sync_q.st[i] <= IDLE_STAGE;
        end else begin
            sync_q <= sync_d;
        end
    end

    // rising strobe seen between the two oldest stages, gated by chip select
    assign wr_en   = sync_q.st[LAST-1].wr_n && !sync_q.st[LAST].wr_n && !sync_q.st[LAST].cs_n;
    assign wr_addr = sync_q.st[LAST].addr;
    assign wr_data = sync_q.st[LAST].data;

    // R2: one commit per strobe edge
    p_single_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
endmodule

// File: rtl/lcd_reg_array.sv
module lcd_reg_array
    import lcd_cfg_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5,
    parameter int N_REGS = 30
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic                           disp_end,
    output logic [N_REGS-1:0][DATA_W-1:0]  regs_q
);
    logic [N_REGS-1:0][DATA_W-1:0] regs_d;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            for (int i = 0; i < N_REGS; i++) begin
                if (wr_addr == ADDR_W'(i)) begin
                    if (i == MODE_ADDR) regs_d[i] = wr_data & DATA_W'(MODE_MASK);
                    else                regs_d[i] = wr_data;
                end
            end
        end
        if (disp_end) regs_d[MODE_ADDR][MB_IDLE] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
            regs_q[MODE_ADDR] <= DATA_W'(MODE_RESET);
        end else begin
            regs_q <= regs_d;
        end
    end

    // R2: a data-register write lands at its address
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != ADDR_W'(MODE_ADDR) && wr_addr < ADDR_W'(N_REGS))
        |=> regs_q[$past(wr_addr)] == $past(wr_data));
    // R3: nothing moves without a commit or a display-end
    p_hold_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !disp_end) |=> $stable(regs_q));
    // R5: unused addresses leave the array alone
    p_unused_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= ADDR_W'(N_REGS) && !disp_end) |=> $stable(regs_q));
    // R9: display-end always returns to idle
    p_end_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        disp_end |=> regs_q[MODE_ADDR][MB_IDLE]);
endmodule

// File: rtl/lcd_read_mux.sv
module lcd_read_mux #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5,
    parameter int N_REGS = 30
) (
    input  logic [ADDR_W-1:0]             rd_addr,
    input  logic [N_REGS-1:0][DATA_W-1:0] regs,
    output logic [DATA_W-1:0]             rd_val
);
    always_comb begin
        rd_val = '0;
        for (int i = 0; i < N_REGS; i++) begin
            if (rd_addr == ADDR_W'(i)) rd_val = regs[i];
        end
    end
endmodule

// File: rtl/lcd_cfg_regs.sv
module lcd_cfg_regs
    import lcd_cfg_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5,
    parameter int N_PULSE = 16,
    parameter int SYNC_STAGES = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [4:0]              bus_addr,
    inout  wire  [7:0]              bus_data,
    input  logic                    bus_cs_n,
    input  logic                    bus_wr_n,
    input  logic                    bus_rd_n,
    input  logic                    disp_end,
    output logic                    ctl_idle_rst,
    output logic                    scan_top_down,
    output logic                    scan_left_right,
    output logic [2:0]              panel_sel,
    output logic                    live_view,
    output logic [15:0]             rows_total,
    output logic [15:0]             cols_total,
    output logic [15:0]             row_first,
    output logic [15:0]             row_last,
    output logic [15:0]             col_first,
    output logic [15:0]             col_last,
    output logic [7:0]              color_order,
    output logic [N_PULSE*8-1:0]    pulse_cfg
);
    localparam int N_REGS = PULSE_BASE + N_PULSE;
    localparam int GEO_W  = 2 * DATA_W;

    logic                          wr_en;
    logic [4:0]                    wr_addr;
    logic [7:0]                    wr_data;
    logic [N_REGS-1:0][DATA_W-1:0] regs;
    logic [DATA_W-1:0]             rd_val;
    logic [N_GEO-1:0][GEO_W-1:0]   geo;

    lcd_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_din(bus_data),
        .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    lcd_reg_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_REGS(N_REGS)) u_array (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .disp_end(disp_end), .regs_q(regs)
    );

    lcd_read_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_REGS(N_REGS)) u_rmux (
        .rd_addr(bus_addr), .regs(regs), .rd_val(rd_val)
    );

    assign bus_data = (!bus_cs_n && !bus_rd_n) ? rd_val : 'z;

    // mode fields
    assign ctl_idle_rst    = regs[MODE_ADDR][MB_IDLE];
    assign scan_top_down   = regs[MODE_ADDR][MB_VDIR];
    assign scan_left_right = regs[MODE_ADDR][MB_HDIR];
    assign panel_sel       = regs[MODE_ADDR][MB_PANEL +: 3];
    assign live_view       = regs[MODE_ADDR][MB_LIVE];

    // geometry pairs, low byte first
    for (genvar g = 0; g < N_GEO; g++) begin : g_geo
        assign geo[g] = {regs[GEO_BASE + 2*g + 1], regs[GEO_BASE + 2*g]};
    end
    assign rows_total = geo[0];
    assign cols_total = geo[1];
    assign row_first  = geo[2];
    assign row_last   = geo[3];
    assign col_first  = geo[4];
    assign col_last   = geo[5];

    assign color_order = regs[COLOR_ADDR];
    for (genvar k = 0; k < N_PULSE; k++) begin : g_pulse
        assign pulse_cfg[8*k +: 8] = regs[PULSE_BASE + k];
    end

    // R10: a committed zero in bit 0 without display-end releases the controller
    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 5'(MODE_ADDR) && !wr_data[MB_IDLE] && !disp_end)
        |=> !ctl_idle_rst);
endmodule

// File: tb/lcd_cfg_regs_bench.sv
module lcd_cfg_regs_bench;
    logic clk = 0;
    logic rst_n = 0;
    logic [4:0] bus_addr = 0;
    logic bus_cs_n = 1, bus_wr_n = 1, bus_rd_n = 1, disp_end = 0;
    logic tb_oe = 0;
    logic [7:0] tb_dout = 0;
    wire  [7:0] bus_data;
    logic ctl_idle_rst, scan_top_down, scan_left_right, live_view;
    logic [2:0] panel_sel;
    logic [15:0] rows_total, cols_total, row_first, row_last, col_first, col_last;
    logic [7:0] color_order;
    logic [127:0] pulse_cfg;

    int n_checks = 0, n_fail = 0;
    logic [7:0] exp_r [32];

    assign bus_data = tb_oe ? tb_dout : 'z;
    always #4 clk = ~clk;

    lcd_cfg_regs u_lcd_cfg_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n),
        .disp_end(disp_end), .ctl_idle_rst(ctl_idle_rst),
        .scan_top_down(scan_top_down), .scan_left_right(scan_left_right),
        .panel_sel(panel_sel), .live_view(live_view),
        .rows_total(rows_total), .cols_total(cols_total),
        .row_first(row_first), .row_last(row_last),
        .col_first(col_first), .col_last(col_last),
        .color_order(color_order), .pulse_cfg(pulse_cfg)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void model_write(input int a, input logic [7:0] d);
        if (a < 30) exp_r[a] = (a == 0) ? (d & 8'h7F) : d;
    endfunction

    // full bus write; with_end pulses disp_end on the commit edge
    task automatic bus_write(input int a, input logic [7:0] d, input logic cs, input logic with_end);
        @(negedge clk);
        bus_addr = 5'(a); tb_dout = d; tb_oe = 1; bus_cs_n = ~cs;
        @(negedge clk); bus_wr_n = 0;
        repeat (3) @(negedge clk);
        bus_wr_n = 1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); disp_end = with_end;
        @(negedge clk); disp_end = 0;
        repeat (3) @(negedge clk);
        bus_cs_n = 1; tb_oe = 0;
        @(negedge clk);
    endtask

    task automatic bus_read(input int a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = 5'(a); bus_cs_n = 0; bus_rd_n = 0;
        #1 v = bus_data;
        @(negedge clk);
        bus_cs_n = 1; bus_rd_n = 1;
    endtask

    task automatic check_all(input string req);
        logic [7:0] v;
        for (int a = 0; a < 32; a++) begin
            bus_read(a, v);
            check(req, v, (a < 30) ? exp_r[a] : 8'h00);
        end
        check({req, " R6 mode fields"},
              {ctl_idle_rst, scan_top_down, scan_left_right, panel_sel, live_view},
              {exp_r[0][0], exp_r[0][1], exp_r[0][2], exp_r[0][5:3], exp_r[0][6]});
        check({req, " R7 geometry"},
              {rows_total, cols_total, row_first, row_last, col_first, col_last},
              {exp_r[2], exp_r[1], exp_r[4], exp_r[3], exp_r[6], exp_r[5],
               exp_r[8], exp_r[7], exp_r[10], exp_r[9], exp_r[12], exp_r[11]});
        check({req, " R8 colour"}, color_order, exp_r[13]);
        for (int k = 0; k < 16; k++)
            check({req, " R8 pulse"}, pulse_cfg[8*k +: 8], exp_r[14+k]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        for (int a = 0; a < 32; a++) exp_r[a] = 8'h00;
        exp_r[0] = 8'h01;
        repeat (3) @(negedge clk);
        rst_n = 1;
        check_all("R1 reset");

        // R2 / R7 / R8: sweep pattern one over all addresses
        for (int a = 0; a < 32; a++) begin
            logic [7:0] d = 8'((a * 37 + 11) & 8'hFF);
            bus_write(a, d, 1'b1, 1'b0);
            model_write(a, d);
        end
        check_all("R2 R5 pattern1");

        // second pattern, inverted
        for (int a = 0; a < 30; a++) begin
            logic [7:0] d = ~8'((a * 37 + 11) & 8'hFF);
            bus_write(a, d, 1'b1, 1'b0);
            model_write(a, d);
        end
        check_all("R2 pattern2");

        // R3: chip select high ignored
        for (int a = 0; a < 30; a += 3) bus_write(a, 8'h5A, 1'b0, 1'b0);
        check_all("R3 cs high");

        // R5: unused addresses
        bus_write(30, 8'hC3, 1'b1, 1'b0);
        bus_write(31, 8'h3C, 1'b1, 1'b0);
        check_all("R5 unused");

        // R6: bit 7 masked
        bus_write(0, 8'hFF, 1'b1, 1'b0); model_write(0, 8'hFF);
        bus_read(0, v); check("R6 bit7 zero", v, 8'h7F);

        // R10: release, then R9 display-end alone
        bus_write(0, 8'h2A, 1'b1, 1'b0); model_write(0, 8'h2A);
        check("R10 released", ctl_idle_rst, 1'b0);
        bus_read(0, v); check("R10 mode value", v, 8'h2A);
        @(negedge clk); disp_end = 1; @(negedge clk); disp_end = 0;
        exp_r[0] = 8'h2B;
        bus_read(0, v); check("R9 end sets idle", v, 8'h2B);
        check("R9 idle out", ctl_idle_rst, 1'b1);

        // R9: same-edge write of bit0=0 with display-end
        bus_write(0, 8'h54, 1'b1, 1'b1);
        exp_r[0] = 8'h55;
        bus_read(0, v); check("R9 end wins", v, 8'h55);
        check_all("R9 after collision");

        // R4: undriven when chip select high
        @(negedge clk);
        bus_addr = 5'd1; tb_dout = 8'h00; tb_oe = 1; bus_cs_n = 1; bus_rd_n = 0;
        #1 check("R4 released cs high", bus_data, 8'h00);
        @(negedge clk);
        bus_cs_n = 0; bus_rd_n = 1;
        #1 check("R4 released rd high", bus_data, 8'h00);
        @(negedge clk);
        bus_cs_n = 1; tb_oe = 0;
        bus_read(1, v); check("R4 read drives", v, exp_r[1]);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule